// File: doc/BRIEF.md
# Split Transaction Credit Limiter

This block decides when transmit-side and receive-side read requests may be issued onto a bus whose reads finish through split completions. It counts the split reads that have been granted but not yet completed. A request is granted only while the count leaves room under the configured limits, and each completion pulse returns one credit. Grants are combinational in the cycle of the request. The count and the completion-error flag are registers.

Two limits apply. A 3-bit code selects the overall ceiling on outstanding splits. A 5-bit shared level holds back transmit requests early, so that receive traffic keeps some credits for itself. Each grant carries the decoded maximum read byte count, so that the requester can size the read.

When both classes are eligible in the same cycle, a two-state round-robin machine chooses between them. `ARB_TX_FIRST` (the reset state) favours transmit. Granting transmit takes the transition `GIVE_TX` to `ARB_RX_FIRST`. In `ARB_RX_FIRST`, granting receive takes the transition `GIVE_RX` back to `ARB_TX_FIRST`. A grant to the class that is not favoured leaves the state where it is. When neither class is granted, the state holds.

Top module: `split_credit_gate`

## Requirements
- R1: After reset the outstanding count is zero, no grant or error is driven, and the first eligible request is granted in the cycle it is raised.
- R2: The ceiling code on `cfg_max_code` decodes as 0→1, 1→2, 2→3, 3→4, 4→8, 5→12, 6→16, 7→32 outstanding splits. No request is granted once the count reaches the ceiling.
- R3: With a non-zero `cfg_shared_lim`, no transmit grant is given while the count is at or above that level. The ceiling still applies when the level exceeds it.
- R4: With `cfg_shared_lim` equal to zero, transmit requests are limited only by the ceiling.
- R5: Receive requests are limited only by the ceiling, whatever the shared level.
- R6: At most one grant is given per cycle, and only to a class that requests it.
- R7: When both classes are eligible, grants alternate. Transmit wins first after reset, and each grant to a class passes priority to the other class.
- R8: A grant and a valid completion in the same cycle leave the count unchanged. Eligibility uses the count held at the start of that cycle.
- R9: A completion while the count is zero leaves the count at zero and raises `cpl_err` for exactly the following cycle.
- R10: During a grant, `gnt_bytes` equals 512 shifted left by `cfg_rd_bytes_code` (0→512, 1→1024, 2→2048, 3→4096). At all other times it is zero.
- R11: A completion with a non-zero count and no grant lowers the count by one, so that one further grant becomes possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_code | input | 3 | Encoded ceiling on outstanding splits |
| cfg_shared_lim | input | 5 | Count at which transmit requests stop being granted (0 = no separate level) |
| cfg_rd_bytes_code | input | 2 | Encoded maximum read byte count |
| tx_req | input | 1 | Transmit read request |
| rx_req | input | 1 | Receive read request |
| cpl_pulse | input | 1 | One split completion returned |
| tx_gnt | output | 1 | Transmit request granted this cycle |
| rx_gnt | output | 1 | Receive request granted this cycle |
| gnt_bytes | output | 13 | Maximum read byte count given with the grant |
| cpl_err | output | 1 | Previous cycle held a completion while no split was outstanding |

## Verification
The checker watches every cycle for the following: no double grants, no grant without a request, no transmit grant at or above the shared level, no grant at the ceiling, a steady count when a grant coincides with a completion, a decrement on a lone completion, the error pulse after a completion at zero, and a zero byte field when there is no grant. Only the bench scenarios show the following: the full decode of every ceiling code, the exact alternation order of the round-robin machine, the byte-count values for each code, and, at the ports, that an ignored completion at zero does not corrupt later credit.

// File: rtl/scg_pkg.sv
package scg_pkg;

    localparam int MAX_CODE_W = 3;
    localparam int CNT_W      = 6;

    typedef enum logic {
        ARB_TX_FIRST = 1'b0,
        ARB_RX_FIRST = 1'b1
    } arb_state_e;

    function automatic logic [CNT_W-1:0] ceiling_of(input logic [MAX_CODE_W-1:0] code);
        logic [CNT_W-1:0] lim;
        unique case (code)
            3'd0: lim = CNT_W'(1);
            3'd1: lim = CNT_W'(2);
            3'd2: lim = CNT_W'(3);
            3'd3: lim = CNT_W'(4);
            3'd4: lim = CNT_W'(8);
            3'd5: lim = CNT_W'(12);
            3'd6: lim = CNT_W'(16);
            default: lim = CNT_W'(32);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/scg_limit_decode.sv
module scg_limit_decode
    import scg_pkg::*;
#(
    parameter int BYTES_CODE_W = 2,
    parameter int BYTES_BASE   = 512,
    localparam int BYTES_W     = $clog2(BYTES_BASE) + (1 << BYTES_CODE_W)
) (
    input  logic [MAX_CODE_W-1:0]   max_code,
    input  logic [BYTES_CODE_W-1:0] bytes_code,
    output logic [CNT_W-1:0]        max_lim,
    output logic [BYTES_W-1:0]      rd_bytes
);

    always_comb begin
        max_lim  = ceiling_of(max_code);
        rd_bytes = BYTES_W'(BYTES_BASE) << bytes_code;
    end

endmodule

// File: rtl/scg_credit_ctr.sv
module scg_credit_ctr
    import scg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give_back,
    output logic [CNT_W-1:0] cnt,
    output logic             bad_cpl
);

    logic [CNT_W-1:0] cnt_d;
    logic             ret_ok;

    always_comb begin
        ret_ok = give_back && (cnt != '0);
        cnt_d  = cnt + CNT_W'(take) - CNT_W'(ret_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            bad_cpl <= 1'b0;
        end else begin
            cnt     <= cnt_d;
            bad_cpl <= give_back && (cnt == '0);
        end
    end

endmodule

// File: rtl/scg_rr_arb.sv
module scg_rr_arb
    import scg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_elig,
    input  logic rx_elig,
    output logic tx_win,
    output logic rx_win
);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_TX_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_TX_FIRST: if (tx_elig) state_d = ARB_RX_FIRST;
            ARB_RX_FIRST: if (rx_elig) state_d = ARB_TX_FIRST;
        endcase
    end

    always_comb begin
        tx_win = 1'b0;
        rx_win = 1'b0;
        unique case (state_q)
            ARB_TX_FIRST: begin
                if (tx_elig)      tx_win = 1'b1;
                else if (rx_elig) rx_win = 1'b1;
            end
            ARB_RX_FIRST: begin
                if (rx_elig)      rx_win = 1'b1;
                else if (tx_elig) tx_win = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/split_credit_gate.sv
module split_credit_gate
    import scg_pkg::*;
#(
    parameter int SHARED_W     = 5,
    parameter int BYTES_CODE_W = 2,
    parameter int BYTES_BASE   = 512,
    localparam int BYTES_W     = $clog2(BYTES_BASE) + (1 << BYTES_CODE_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MAX_CODE_W-1:0]   cfg_max_code,
    input  logic [SHARED_W-1:0]     cfg_shared_lim,
    input  logic [BYTES_CODE_W-1:0] cfg_rd_bytes_code,
    input  logic                    tx_req,
    input  logic                    rx_req,
    input  logic                    cpl_pulse,
    output logic                    tx_gnt,
    output logic                    rx_gnt,
    output logic [BYTES_W-1:0]      gnt_bytes,
    output logic                    cpl_err
);

    logic [CNT_W-1:0]   max_lim;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTES_W-1:0] rd_bytes;
    logic               room, tx_room, tx_elig, rx_elig, any_gnt;

    scg_limit_decode #(
        .BYTES_CODE_W (BYTES_CODE_W),
        .BYTES_BASE   (BYTES_BASE)
    ) u_dec (
        .max_code   (cfg_max_code),
        .bytes_code (cfg_rd_bytes_code),
        .max_lim    (max_lim),
        .rd_bytes   (rd_bytes)
    );

    always_comb begin
        room    = cnt_q < max_lim;
        tx_room = room && ((cfg_shared_lim == '0) || (cnt_q < CNT_W'(cfg_shared_lim)));
        tx_elig = rst_n && tx_req && tx_room;
        rx_elig = rst_n && rx_req && room;
    end

    scg_rr_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_elig (tx_elig),
        .rx_elig (rx_elig),
        .tx_win  (tx_gnt),
        .rx_win  (rx_gnt)
    );

    assign any_gnt   = tx_gnt || rx_gnt;
    assign gnt_bytes = any_gnt ? rd_bytes : '0;

    scg_credit_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (any_gnt),
        .give_back (cpl_pulse),
        .cnt       (cnt_q),
        .bad_cpl   (cpl_err)
    );

endmodule

// File: rtl/scg_checker.sv
module scg_checker
    import scg_pkg::*;
#(
    parameter int SHARED_W = 5,
    parameter int BYTES_W  = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_req,
    input logic                rx_req,
    input logic                tx_gnt,
    input logic                rx_gnt,
    input logic                cpl_pulse,
    input logic                cpl_err,
    input logic [BYTES_W-1:0]  gnt_bytes,
    input logic [SHARED_W-1:0] shared_lim,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    max_lim
);

    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_gnt && rx_gnt));

    a_r6_tx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_gnt |-> tx_req);

    a_r6_rx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rx_gnt |-> rx_req);

    a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= max_lim) |-> !(tx_gnt || rx_gnt));

    a_r3_shared_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((shared_lim != '0) && (cnt >= CNT_W'(shared_lim))) |-> !tx_gnt);

    a_r8_balance: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_gnt || rx_gnt) && cpl_pulse && (cnt != '0)) |=> $stable(cnt));

    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tx_gnt || rx_gnt) && cpl_pulse && (cnt != '0)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_pulse && (cnt == '0)) |=> cpl_err);

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpl_pulse || (cnt != '0)) |=> !cpl_err);

    a_r10_bytes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_gnt || rx_gnt) |-> (gnt_bytes == '0));

endmodule

bind split_credit_gate scg_checker #(
    .SHARED_W (SHARED_W),
    .BYTES_W  (BYTES_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .rx_req     (rx_req),
    .tx_gnt     (tx_gnt),
    .rx_gnt     (rx_gnt),
    .cpl_pulse  (cpl_pulse),
    .cpl_err    (cpl_err),
    .gnt_bytes  (gnt_bytes),
    .shared_lim (cfg_shared_lim),
    .cnt        (cnt_q),
    .max_lim    (max_lim)
);

// File: tb/split_credit_gate_tb.sv
module split_credit_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_max_code = '0;
    logic [4:0]  cfg_shared_lim = '0;
    logic [1:0]  cfg_rd_bytes_code = '0;
    logic        tx_req = 1'b0;
    logic        rx_req = 1'b0;
    logic        cpl_pulse = 1'b0;
    logic        tx_gnt, rx_gnt, cpl_err;
    logic [12:0] gnt_bytes;

    always #5 clk = ~clk;

    split_credit_gate u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_max_code      (cfg_max_code),
        .cfg_shared_lim    (cfg_shared_lim),
        .cfg_rd_bytes_code (cfg_rd_bytes_code),
        .tx_req            (tx_req),
        .rx_req            (rx_req),
        .cpl_pulse         (cpl_pulse),
        .tx_gnt            (tx_gnt),
        .rx_gnt            (rx_gnt),
        .gnt_bytes         (gnt_bytes),
        .cpl_err           (cpl_err)
    );

    typedef struct {
        logic        tx;
        logic        rx;
        logic [12:0] bytes;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // reference state, built from the requirements
    int   m_cnt = 0;
    bit   m_tx_first = 1;
    bit   m_err_next = 0;
    int   m_code = 0;
    int   m_sh = 0;
    int   m_bc = 0;

    function automatic int ceil_of(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 3;  3: return 4;
            4: return 8;  5: return 12; 6: return 16; default: return 32;
        endcase
    endfunction

    task automatic step(input bit txr, input bit rxr, input bit cpl, input string tag);
        exp_t e;
        bit   tok, rok, gt, gr;
        int   mx;
        @(posedge clk);
        #1;
        cfg_max_code      = 3'(m_code);
        cfg_shared_lim    = 5'(m_sh);
        cfg_rd_bytes_code = 2'(m_bc);
        tx_req = txr; rx_req = rxr; cpl_pulse = cpl;
        mx  = ceil_of(m_code);
        rok = m_cnt < mx;
        tok = rok && (m_sh == 0 || m_cnt < m_sh);
        gt  = txr && tok && (!(rxr && rok) || m_tx_first);
        gr  = rxr && rok && !gt;
        if (gt) m_tx_first = 0;
        if (gr) m_tx_first = 1;
        e.tx    = gt;
        e.rx    = gr;
        e.bytes = (gt || gr) ? 13'(512 << m_bc) : 13'd0;
        e.err   = m_err_next;
        e.tag   = tag;
        exp_q.push_back(e);
        m_err_next = cpl && (m_cnt == 0);
        if (cpl && m_cnt != 0) m_cnt = m_cnt - 1;
        if (gt || gr) m_cnt = m_cnt + 1;
    endtask

    task automatic drain(input string tag);
        while (m_cnt > 0) step(0, 0, 1, tag);
        step(0, 0, 0, tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (tx_gnt !== e.tx || rx_gnt !== e.rx || gnt_bytes !== e.bytes || cpl_err !== e.err) begin
                n_errors++;
                $display("FAIL %s: got tx=%0b rx=%0b bytes=%0d err=%0b, expected tx=%0b rx=%0b bytes=%0d err=%0b",
                         e.tag, tx_gnt, rx_gnt, gnt_bytes, cpl_err, e.tx, e.rx, e.bytes, e.err);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (tx_gnt !== 1'b0 || rx_gnt !== 1'b0 || cpl_err !== 1'b0 || gnt_bytes !== 13'd0) begin
            n_errors++;
            $display("FAIL R1: got tx=%0b rx=%0b err=%0b bytes=%0d, expected all zero",
                     tx_gnt, rx_gnt, cpl_err, gnt_bytes);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 first grant, R2 ceiling of one
        m_code = 0; m_sh = 0; m_bc = 0;
        step(0, 1, 0, "R1");
        step(0, 1, 0, "R2");
        drain("R11");

        // R9: completion at zero is flagged and ignored
        step(0, 0, 1, "R9");
        step(0, 0, 0, "R9");
        step(0, 1, 0, "R9");
        step(0, 1, 0, "R9");
        drain("R9");

        // R2: every ceiling code
        for (int c = 0; c < 8; c++) begin
            m_code = c;
            repeat (ceil_of(c) + 1) step(0, 1, 0, "R2");
            drain("R2");
        end

        // R3 with R5: shared level 2 under ceiling 8
        m_code = 4; m_sh = 2;
        repeat (3) step(1, 0, 0, "R3");
        repeat (7) step(0, 1, 0, "R5");
        step(1, 0, 0, "R3");
        drain("R3");

        // R3: shared level above the ceiling
        m_code = 2; m_sh = 20;
        repeat (4) step(1, 0, 0, "R3");
        drain("R3");

        // R4: full sharing
        m_code = 3; m_sh = 0;
        repeat (5) step(1, 0, 0, "R4");
        drain("R4");

        // R7 and R6: both requesting
        m_code = 7; m_sh = 0;
        repeat (8) step(1, 1, 0, "R7");
        step(0, 0, 0, "R6");
        drain("R7");
        m_code = 1;
        step(0, 1, 0, "R7");
        repeat (3) step(1, 1, 0, "R7");
        drain("R7");

        // R8 and R11 at the ceiling
        m_code = 3;
        repeat (4) step(0, 1, 0, "R8");
        step(0, 1, 1, "R11");
        step(0, 1, 1, "R8");
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R8");
        drain("R8");

        // R10: byte count per code
        for (int b = 0; b < 4; b++) begin
            m_bc = b;
            step(0, 1, 0, "R10");
            step(1, 0, 1, "R10");
            step(0, 0, 1, "R10");
        end
        drain("R10");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule